// File: doc/BRIEF.md
# Variable-Length Operand Specifier Decoder

The block takes one 48-bit operation word. It splits off the 14-bit header, which holds a condition mode, the index of the stack that the condition tests, and a 9-bit opcode. It then walks the 34-bit tail from its most significant bit downward. The tail is packed with prefix-coded operand specifiers whose lengths run from 6 to 34 bits.

Each clock cycle the block peels off one specifier. It records the specifier's kind, up to two stack indices and a zero-extended immediate or offset in a numbered slot. Walking stops when the bits that remain cannot hold the next specifier, or when every slot is full. At that point the block pulses `done`, and the slots, the count and the header fields stay steady until the next accepted start.

The condition mode is turned into a guard enable. The guard is evaluated against the top-of-stack value that the surrounding pipeline drives in. A later stage uses the slot list to assign destinations and sources and to execute the operation.

Top module: `opspec_decoder`

## Requirements
- R1: A start pulse accepted while idle latches the header. The mode is bits 47:46, the condition stack index is bits 45:43 and the opcode is bits 42:34. These appear on `cond_mode`, `cond_stack` and `opcode` and hold until the next accepted start.
- R2: `guard_en` is 1 for mode 0 and follows `cond_top == 0` for mode 1. For mode 2 it follows `cond_top != 0`, and for mode 3 it follows `cond_top[0]`. It is evaluated against the current `cond_top` and the latched mode.
- R3: The specifier field is bits 33:0, read from bit 33 downward. Each specifier starts at the bit right after the previous one, and slot 0 holds the first specifier.
- R4: Prefix and kind code (4 bits per slot, slot i at `spec_kind[4i+3:4i]`), with total length:
  - 000+3 gives stack pop/push, kind 0, 6 bits.
  - 001+3 gives peek/push-if-empty, kind 1, 6 bits.
  - 010+8 gives 8-bit immediate, kind 2, 11 bits.
  - 011+16 gives 16-bit immediate, kind 3, 19 bits.
  - 100+31 gives 31-bit immediate, kind 4, 34 bits.
  - 101+16 gives offset from the condition stack's base register, kind 5, 19 bits.
  - 110+16 gives offset from the condition stack's top, kind 6, 19 bits.
  - 1110+3 gives a base register, kind 7, 7 bits.
  - 1111+3+3 gives base of the first stack plus top of the second, kind 8, 10 bits.
- R5: Stack indices go to `spec_idx_a`, and the second index of kind 8 goes to `spec_idx_b`. For kinds 5 and 6, `spec_idx_a` carries the condition stack index. Immediates and offsets are zero-extended into the 31-bit `spec_imm` slot. Fields a kind does not use read 0.
- R6: Walking ends in three cases, and the trailing bits are left unused. The first is fewer than 3 bits remaining. The second is a 111 prefix with fewer than 4 bits remaining. The third is a specifier longer than the bits remaining. A specifier that ends exactly at bit 0 is still decoded.
- R7: One specifier is taken per clock. For k specifiers, `done` is high for exactly one cycle, k+1 clock edges after the edge that accepted start. `busy` is high from the accepting edge until `done` rises.
- R8: A start pulse while `busy` is high is ignored. The header and the slots are those of the word that was accepted.
- R9: After reset, `busy`, `done`, `spec_count` and `spec_valid` are all 0.
- R10: `spec_count` never exceeds 8. When `done` is high, `spec_valid` has exactly its low `spec_count` bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin decoding `op_word` (taken only while idle) |
| op_word | input | 48 | Operation word |
| cond_top | input | 64 | Current top value of the condition stack |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse when the walk ends |
| cond_mode | output | 2 | Latched condition mode |
| cond_stack | output | 3 | Latched condition stack index |
| opcode | output | 9 | Latched opcode |
| guard_en | output | 1 | Condition result for the current `cond_top` |
| spec_count | output | 4 | Number of decoded specifiers |
| spec_valid | output | 8 | Per-slot valid flags |
| spec_kind | output | 32 | Kind code per slot, 4 bits each |
| spec_idx_a | output | 24 | First stack index per slot, 3 bits each |
| spec_idx_b | output | 24 | Second stack index per slot, 3 bits each |
| spec_imm | output | 248 | Immediate or offset per slot, 31 bits each |

## Verification
The header fields are due one edge after the accepting edge. `guard_en` is combinational on the latched mode and `cond_top`, so the bench reads it half a cycle after changing `cond_top`. `done` is due k+1 edges after acceptance. The bench counts clock edges from the accepting edge and samples every output on the falling edge, so it can check that `done` arrives on exactly the expected edge. The slot contents, the count and the valid mask are read in that same `done` cycle.

// File: rtl/opspec_pkg.sv
package opspec_pkg;
   localparam int HDR_W   = 14;
   localparam int KIND_W  = 4;
   localparam int IDX_W   = 3;
   localparam int IMM_W   = 31;
   localparam int LEN_W   = 6;

   typedef enum logic [KIND_W-1:0] {
      K_STACK     = 4'd0,
      K_PEEK      = 4'd1,
      K_IMM8      = 4'd2,
      K_IMM16     = 4'd3,
      K_IMM31     = 4'd4,
      K_BASE_OFS  = 4'd5,
      K_TOP_OFS   = 4'd6,
      K_BASE_REG  = 4'd7,
      K_BASE_TOP  = 4'd8
   } spec_kind_e;

   typedef struct packed {
      spec_kind_e           kind;
      logic [IDX_W-1:0]     idx_a;
      logic [IDX_W-1:0]     idx_b;
      logic [IMM_W-1:0]     imm;
   } spec_t;
endpackage

// File: rtl/opspec_guard.sv
module opspec_guard #(
   parameter int DATA_W = 64
) (
   input  logic [1:0]        mode,
   input  logic [DATA_W-1:0] top,
   output logic              enable
);
   always_comb begin
      unique case (mode)
         2'd0:    enable = 1'b1;
         2'd1:    enable = (top == '0);
         2'd2:    enable = (top != '0);
         default: enable = top[0];
      endcase
   end
endmodule

// File: rtl/opspec_classify.sv
module opspec_classify
   import opspec_pkg::*;
#(
   parameter int FIELD_W = 34
) (
   input  logic [FIELD_W-1:0] win,
   input  logic [LEN_W-1:0]   remain,
   input  logic [IDX_W-1:0]   cond_stk,
   output spec_t              spec,
   output logic [LEN_W-1:0]   len,
   output logic               fits
);
   localparam int T = FIELD_W - 1;

   logic [2:0] pfx;
   logic       readable;

   assign pfx = win[T -: 3];

   always_comb begin
      spec     = '0;
      len      = '0;
      readable = (remain >= LEN_W'(3)) &&
                 ((pfx != 3'b111) || (remain >= LEN_W'(4)));
      unique case (pfx)
         3'b000, 3'b001: begin
            spec.kind  = (pfx[0]) ? K_PEEK : K_STACK;
            spec.idx_a = win[T-3 -: 3];
            len        = LEN_W'(6);
         end
         3'b010: begin
            spec.kind = K_IMM8;
            spec.imm  = IMM_W'(win[T-3 -: 8]);
            len       = LEN_W'(11);
         end
         3'b011: begin
            spec.kind = K_IMM16;
            spec.imm  = IMM_W'(win[T-3 -: 16]);
            len       = LEN_W'(19);
         end
         3'b100: begin
            spec.kind = K_IMM31;
            spec.imm  = win[T-3 -: 31];
            len       = LEN_W'(34);
         end
         3'b101, 3'b110: begin
            spec.kind  = (pfx[0]) ? K_BASE_OFS : K_TOP_OFS;
            spec.idx_a = cond_stk;
            spec.imm   = IMM_W'(win[T-3 -: 16]);
            len        = LEN_W'(19);
         end
         default: begin
            spec.idx_a = win[T-4 -: 3];
            if (win[T-3]) begin
               spec.kind  = K_BASE_TOP;
               spec.idx_b = win[T-7 -: 3];
               len        = LEN_W'(10);
            end else begin
               spec.kind = K_BASE_REG;
               len       = LEN_W'(7);
            end
         end
      endcase
      fits = readable && (len <= remain);
   end
endmodule

// File: rtl/opspec_decoder.sv
module opspec_decoder
   import opspec_pkg::*;
#(
   parameter int OP_W      = 48,
   parameter int DATA_W    = 64,
   parameter int MAX_SPECS = 8,
   parameter int CNT_W     = $clog2(MAX_SPECS + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic [OP_W-1:0]             op_word,
   input  logic [DATA_W-1:0]           cond_top,
   output logic                        busy,
   output logic                        done,
   output logic [1:0]                  cond_mode,
   output logic [IDX_W-1:0]            cond_stack,
   output logic [8:0]                  opcode,
   output logic                        guard_en,
   output logic [CNT_W-1:0]            spec_count,
   output logic [MAX_SPECS-1:0]        spec_valid,
   output logic [MAX_SPECS*KIND_W-1:0] spec_kind,
   output logic [MAX_SPECS*IDX_W-1:0]  spec_idx_a,
   output logic [MAX_SPECS*IDX_W-1:0]  spec_idx_b,
   output logic [MAX_SPECS*IMM_W-1:0]  spec_imm
);
   localparam int FIELD_W = OP_W - HDR_W;

   if (FIELD_W != 34) begin : g_bad_width
      $error("opspec_decoder: OP_W must leave a 34-bit specifier field");
   end
   if (MAX_SPECS < 1 || MAX_SPECS > 15) begin : g_bad_slots
      $error("opspec_decoder: MAX_SPECS out of range");
   end

   logic [FIELD_W-1:0] sh_q;
   logic [LEN_W-1:0]   rem_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               busy_q, done_q;
   logic [1:0]         mode_q;
   logic [IDX_W-1:0]   cstk_q;
   logic [8:0]         opc_q;

   spec_t              cur;
   logic [LEN_W-1:0]   cur_len;
   logic               cur_fits;
   logic               accept, take;

   opspec_classify #(.FIELD_W(FIELD_W)) u_classify (
      .win      (sh_q),
      .remain   (rem_q),
      .cond_stk (cstk_q),
      .spec     (cur),
      .len      (cur_len),
      .fits     (cur_fits)
   );

   opspec_guard #(.DATA_W(DATA_W)) u_guard (
      .mode   (mode_q),
      .top    (cond_top),
      .enable (guard_en)
   );

   assign accept = start && !busy_q;
   assign take   = busy_q && cur_fits && (cnt_q < CNT_W'(MAX_SPECS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         rem_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         mode_q <= '0;
         cstk_q <= '0;
         opc_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            mode_q <= op_word[OP_W-1 -: 2];
            cstk_q <= op_word[OP_W-3 -: 3];
            opc_q  <= op_word[OP_W-6 -: 9];
            sh_q   <= op_word[FIELD_W-1:0];
            rem_q  <= LEN_W'(FIELD_W);
            cnt_q  <= '0;
            busy_q <= 1'b1;
         end else if (take) begin
            sh_q  <= sh_q << cur_len;
            rem_q <= rem_q - cur_len;
            cnt_q <= cnt_q + 1'b1;
         end else if (busy_q) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end
      end
   end

   for (genvar i = 0; i < MAX_SPECS; i++) begin : g_slot
      spec_t slot_q;
      logic  vld_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q <= '0;
            vld_q  <= 1'b0;
         end else if (accept) begin
            slot_q <= '0;
            vld_q  <= 1'b0;
         end else if (take && cnt_q == CNT_W'(i)) begin
            slot_q <= cur;
            vld_q  <= 1'b1;
         end
      end
      assign spec_valid[i]                = vld_q;
      assign spec_kind[i*KIND_W +: KIND_W] = slot_q.kind;
      assign spec_idx_a[i*IDX_W +: IDX_W]  = slot_q.idx_a;
      assign spec_idx_b[i*IDX_W +: IDX_W]  = slot_q.idx_b;
      assign spec_imm[i*IMM_W +: IMM_W]    = slot_q.imm;
   end

   assign busy       = busy_q;
   assign done       = done_q;
   assign cond_mode  = mode_q;
   assign cond_stack = cstk_q;
   assign opcode     = opc_q;
   assign spec_count = cnt_q;

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                   // R7
   AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      spec_count <= CNT_W'(MAX_SPECS));                                  // R10
   AST_VALID_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($countones(spec_valid) == int'(spec_count)));            // R10
   AST_HDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(opcode) && $stable(cond_stack))); // R8
   AST_TAKE_FITS: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (rem_q < $past(rem_q)));                                  // R6
   AST_GUARD_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_mode == 2'd0) |-> guard_en);                                 // R2
endmodule

// File: tb/opspec_decoder_bench.sv
`timescale 1ns/1ps
module opspec_decoder_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [47:0]  op_word = '0;
   logic [63:0]  cond_top = '0;
   logic         busy, done, guard_en;
   logic [1:0]   cond_mode;
   logic [2:0]   cond_stack;
   logic [8:0]   opcode;
   logic [3:0]   spec_count;
   logic [7:0]   spec_valid;
   logic [31:0]  spec_kind;
   logic [23:0]  spec_idx_a, spec_idx_b;
   logic [247:0] spec_imm;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   opspec_decoder u_opspec_decoder (
      .clk(clk), .rst_n(rst_n), .start(start), .op_word(op_word),
      .cond_top(cond_top), .busy(busy), .done(done), .cond_mode(cond_mode),
      .cond_stack(cond_stack), .opcode(opcode), .guard_en(guard_en),
      .spec_count(spec_count), .spec_valid(spec_valid), .spec_kind(spec_kind),
      .spec_idx_a(spec_idx_a), .spec_idx_b(spec_idx_b), .spec_imm(spec_imm)
   );

   localparam int NV = 8;
   localparam logic [33:0] FLD [NV] = '{
      {6'b000101, 6'b001010, 6'b000111, 6'b001000, 6'b000011, 4'b0000},
      {3'b100, 31'h5A5A1234},
      {3'b011, 16'hBEEF, 3'b010, 8'hC3, 4'b1110},
      {4'b1111, 3'd3, 3'd6, 4'b1110, 3'd5, 3'b000, 3'd1, 3'b001, 3'd4, 5'b11111},
      {3'b110, 16'h8001, 4'b1110, 3'd2, 8'b11000000},
      {3'b101, 16'h00FF, 3'b000, 3'd6, 3'b001, 3'd7, 3'b000},
      {3'b011, 16'h0001, 3'b000, 3'd2, 4'b1110, 3'd3, 2'b11},
      {4'b1111, 3'd7, 3'd0, 3'b000, 3'd1, 3'b001, 3'd2, 3'b000, 3'd3, 3'b001, 3'd4}
   };
   localparam int          CNT [NV]   = '{5, 1, 2, 4, 2, 3, 3, 5};
   localparam logic [19:0] KINDS [NV] = '{20'h01010, 20'h00004, 20'h00023,
      20'h01078, 20'h00076, 20'h00105, 20'h00703, 20'h10108};
   localparam logic [2:0]  IA0 [NV]   = '{3'd5, 3'd0, 3'd0, 3'd3, 3'd4, 3'd4, 3'd0, 3'd7};
   localparam logic [2:0]  IB0 [NV]   = '{3'd0, 3'd0, 3'd0, 3'd6, 3'd0, 3'd0, 3'd0, 3'd0};
   localparam logic [30:0] IM0 [NV]   = '{31'd0, 31'h5A5A1234, 31'hBEEF, 31'd0,
      31'h8001, 31'h00FF, 31'h0001, 31'd0};

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Start a decode and return the edge count (from the accepting edge) at which done shows.
   task automatic run(input logic [47:0] w, output int lat);
      @(negedge clk);
      op_word = w;
      start   = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat   = 1;
      while (!done && lat < 60) begin
         @(posedge clk);
         @(negedge clk);
         if (!done) lat++;
      end
      lat = lat;
   endtask

   initial begin
      #1_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hang expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int lat;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(busy == 0 && done == 0, "R9", "busy/done in reset", {busy, done}, 0);
      chk(spec_count == 0 && spec_valid == 0, "R9", "count/valid in reset",
          {spec_count, spec_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 0 && spec_count == 0, "R9", "idle after reset", {busy, spec_count}, 0);

      // Vector table: R1 R3 R4 R5 R6 R7 R10
      for (int v = 0; v < NV; v++) begin
         logic [8:0] opc;
         opc = 9'h100 + 9'(v);
         run({2'd0, 3'd4, opc, FLD[v]}, lat);
         chk(lat == CNT[v] + 1, "R7", $sformatf("done latency v%0d", v), lat, CNT[v] + 1);
         chk(spec_count == 4'(CNT[v]), "R6", $sformatf("count v%0d", v), spec_count, CNT[v]);
         chk(spec_valid == 8'((1 << CNT[v]) - 1), "R10", $sformatf("valid v%0d", v),
             spec_valid, (1 << CNT[v]) - 1);
         for (int s = 0; s < CNT[v]; s++)
            chk(spec_kind[s*4 +: 4] == KINDS[v][s*4 +: 4], "R4",
                $sformatf("kind v%0d slot%0d (R3 order)", v, s),
                spec_kind[s*4 +: 4], KINDS[v][s*4 +: 4]);
         chk(spec_idx_a[2:0] == IA0[v] && spec_idx_b[2:0] == IB0[v], "R5",
             $sformatf("indices v%0d", v), {spec_idx_a[2:0], spec_idx_b[2:0]},
             {IA0[v], IB0[v]});
         chk(spec_imm[30:0] == IM0[v], "R5", $sformatf("imm v%0d", v), spec_imm[30:0], IM0[v]);
         chk(opcode == opc && cond_stack == 3'd4, "R1", $sformatf("header v%0d", v),
             {opcode, cond_stack}, {opc, 3'd4});
         @(negedge clk);
         chk(done == 0, "R7", "done single cycle", done, 0);
      end

      // R2 guard per mode
      for (int m = 0; m < 4; m++) begin
         run({2'(m), 3'd2, 9'h0AA, FLD[1]}, lat);
         chk(cond_mode == 2'(m), "R1", "mode latched", cond_mode, m);
         for (int t = 0; t < 4; t++) begin
            logic [63:0] tv;
            bit exp;
            tv = (t == 0) ? 64'd0 : (t == 1) ? 64'd6 : (t == 2) ? 64'd7 : 64'h8000_0000_0000_0000;
            cond_top = tv;
            #1;
            exp = (m == 0) ? 1'b1 : (m == 1) ? (tv == 0) : (m == 2) ? (tv != 0) : tv[0];
            chk(guard_en == exp, "R2", $sformatf("guard mode%0d top=%0h", m, tv), guard_en, exp);
         end
      end

      // R8 start during busy is ignored
      @(negedge clk);
      op_word = {2'd0, 3'd1, 9'h033, FLD[0]};
      start   = 1'b1;
      @(negedge clk);
      op_word = {2'd3, 3'd6, 9'h1FF, FLD[1]};
      @(negedge clk);
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      chk(opcode == 9'h033 && cond_stack == 3'd1, "R8", "header kept", opcode, 9'h033);
      chk(spec_count == 4'd5 && spec_kind[3:0] == 4'd0, "R8", "slots kept",
          {spec_count, spec_kind[3:0]}, {4'd5, 4'd0});
      @(negedge clk);
      chk(busy == 0, "R8", "no second walk", busy, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule